// File: doc/BRIEF.md
# CAN FD Receive Descriptor Ring Writer

This block takes received classic CAN and CAN FD frames, one per handshake, and stores each one into a circular buffer in memory. The buffer is made of 16-byte descriptors and is reached through a 64-bit synchronous write port. Each stored frame starts with a 64-bit header. The low 32 bits (word 0) hold the identifier and the frame type. The high 32 bits (word 1) hold the length code, the FD option bits and the controller status. The header is followed by the payload doublewords. A long FD frame spans several descriptors, and its payload may wrap past the end of the ring back to offset 0.

Software owns the ring size, an enable input and the read pointer. The block owns the write pointer and only moves it once a frame has been written in full, so a reader never sees half a frame. Equal pointers always mean an empty ring. For that reason the block always keeps at least one descriptor free. A frame that does not fit is dropped, and the drop is reported in the overrun bit of the next header that gets stored.

Top module: `rdesc_ring_writer`

## Requirements
- R1: Header word 0 (memory bits 31:0 of the header doubleword) has bit 31 = extended identifier and bit 30 = remote request. An extended identifier occupies bits 28:0. A standard identifier (the low 12 bits of `frm_id`) occupies bits 29:18, and all other bits are 0.
- R2: Header word 1 (memory bits 63:32) holds the 4-bit length code in bits 31:28 and `frm_fdo` in bits 27:25. Bit 2 is overrun, bit 1 is bus-off and bit 0 is error-passive. The status bits are sampled when the frame is accepted, and all other bits are 0.
- R3: When `frm_fdo[0]` is 1 (FD frame), the code maps to 0..8, 12, 16, 20, 24, 32, 48 or 64 bytes. Otherwise any code above 8 means 8 bytes. The block writes ceil(len/8) payload doublewords. Doubleword k holds `frm_data[64k+63:64k]`, and the first one sits 8 bytes after the header.
- R4: A frame of len bytes uses 1 + ((len+7) >> 4) descriptors. After the frame, `wr_ptr` advances by 16 bytes per descriptor, and the ring size is subtracted when the result reaches or passes it.
- R5: A payload doubleword whose address would reach or pass the ring size is written at offset 0 onwards instead.
- R6: A frame is stored only if its descriptor count is at most the free descriptors minus one. `wr_ptr` never becomes equal to `sw_rd_ptr` by filling the ring.
- R7: A frame that is refused for lack of space makes no memory write and leaves `wr_ptr` unchanged. It sets the overrun bit, which appears in the next stored header and is then cleared.
- R8: `wr_ptr` changes only in the cycle after the last memory write of a frame.
- R9: While `cfg_enable` is 0, frames are consumed with no memory write, no change to `wr_ptr` and no change to the overrun state.
- R10: After reset, `wr_ptr` is 0, `frm_ready` is 1 and `mem_we` is 0.
- R11: `frm_ready` is 0 while a frame is being written. A frame that is accepted makes exactly 1 + ceil(len/8) memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Receive enable |
| cfg_size | input | PTR_W | Ring size in bytes, multiple of 16 |
| sw_rd_ptr | input | PTR_W | Read pointer owned by software, in bytes |
| wr_ptr | output | PTR_W | Write pointer, in bytes |
| frm_valid | input | 1 | Frame present |
| frm_ready | output | 1 | Block is idle and takes a frame |
| frm_ext | input | 1 | Extended identifier |
| frm_rtr | input | 1 | Remote request |
| frm_id | input | 29 | Identifier |
| frm_dlc | input | 4 | Length code |
| frm_fdo | input | 3 | FD options, bit 0 = FD frame |
| frm_data | input | 512 | Payload, byte 0 in bits 7:0 |
| st_busoff | input | 1 | Controller bus-off status |
| st_passive | input | 1 | Controller error-passive status |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | PTR_W-3 | Doubleword address |
| mem_wdata | output | 64 | Write data |

## Verification
The bench goes after the following corner cases.

- **FD frame wrapping past the end of a 128-byte ring.** An off-by-one wrap would scribble past the ring or misplace doublewords.
- **Write pointer landing exactly on the ring size.** A design that compares with greater-than instead of greater-or-equal would leave the pointer out of range.
- **Ring one frame short of full, and exactly full with the one-descriptor gap.** A design without the gap would make a full ring look empty.
- **Overrun bit after a dropped frame.** A design that forgets the flag, or never clears it, would corrupt the next two headers.
- **Disabled input.** A design that writes while disabled would move the pointer.
- **Classic codes above 8, and FD codes such as 9.** A wrong length table would show up as a wrong write count.

// File: rtl/rdesc_pkg.sv
package rdesc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_COMMIT
    } rd_state_e;

    localparam int HW_EXT_BIT  = 31;
    localparam int HW_RTR_BIT  = 30;
    localparam int STD_ID_LSB  = 18;
    localparam int DLC_LSB     = 28;
    localparam int FDO_LSB     = 25;
    localparam int OVR_BIT     = 2;
    localparam int BOFF_BIT    = 1;
    localparam int EPAS_BIT    = 0;
    localparam int DESC_BYTES  = 16;
    localparam int DWORD_BYTES = 8;

    // byte count carried by an FD length code
    function automatic logic [6:0] fd_bytes(input logic [3:0] code);
        logic [6:0] n;
        case (code)
            4'd9:    n = 7'd12;
            4'd10:   n = 7'd16;
            4'd11:   n = 7'd20;
            4'd12:   n = 7'd24;
            4'd13:   n = 7'd32;
            4'd14:   n = 7'd48;
            4'd15:   n = 7'd64;
            default: n = {3'b000, code};
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rdesc_len_decode.sv
module rdesc_len_decode (
    input  logic       is_fd,
    input  logic [3:0] dlc,
    output logic [6:0] len_bytes,
    output logic [2:0] n_desc,
    output logic [3:0] n_dword
);
    import rdesc_pkg::*;

    logic [7:0] len_p7;

    always_comb begin
        if (is_fd) begin
            len_bytes = fd_bytes(dlc);
        end else if (dlc > 4'd8) begin
            len_bytes = 7'd8;
        end else begin
            len_bytes = {3'b000, dlc};
        end
        len_p7  = {1'b0, len_bytes} + 8'd7;
        n_dword = len_p7[6:3];
        n_desc  = 3'd1 + len_p7[6:4];
    end

endmodule

// File: rtl/rdesc_free_space.sv
module rdesc_free_space #(
    parameter int PTR_W = 12
) (
    input  logic [PTR_W-1:0] wp,
    input  logic [PTR_W-1:0] rp,
    input  logic [PTR_W-1:0] size,
    output logic [PTR_W-5:0] free_desc
);
    logic [PTR_W-1:0] gap;

    always_comb begin
        if (wp == rp) begin
            gap = size;
        end else if (wp > rp) begin
            gap = size - wp + rp;
        end else begin
            gap = rp - wp;
        end
        // one descriptor always stays unused
        if (gap[PTR_W-1:4] == '0) begin
            free_desc = '0;
        end else begin
            free_desc = gap[PTR_W-1:4] - 1'b1;
        end
    end

endmodule

// File: rtl/rdesc_ring_add.sv
module rdesc_ring_add #(
    parameter int PTR_W = 12
) (
    input  logic [PTR_W-1:0] base,
    input  logic [PTR_W-1:0] step,
    input  logic [PTR_W-1:0] size,
    output logic [PTR_W-1:0] result
);
    logic [PTR_W:0] sum;
    logic [PTR_W:0] fold;

    always_comb begin
        sum  = {1'b0, base} + {1'b0, step};
        fold = sum - {1'b0, size};
        if (sum >= {1'b0, size}) begin
            result = fold[PTR_W-1:0];
        end else begin
            result = sum[PTR_W-1:0];
        end
    end

endmodule

// File: rtl/rdesc_ring_writer.sv
module rdesc_ring_writer #(
    parameter int PTR_W   = 12,
    parameter int MAX_DW  = 8,
    parameter int ID_W    = 29
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_enable,
    input  logic [PTR_W-1:0]     cfg_size,
    input  logic [PTR_W-1:0]     sw_rd_ptr,
    output logic [PTR_W-1:0]     wr_ptr,
    input  logic                 frm_valid,
    output logic                 frm_ready,
    input  logic                 frm_ext,
    input  logic                 frm_rtr,
    input  logic [ID_W-1:0]      frm_id,
    input  logic [3:0]           frm_dlc,
    input  logic [2:0]           frm_fdo,
    input  logic [MAX_DW*64-1:0] frm_data,
    input  logic                 st_busoff,
    input  logic                 st_passive,
    output logic                 mem_we,
    output logic [PTR_W-4:0]     mem_addr,
    output logic [63:0]          mem_wdata
);
    import rdesc_pkg::*;

    localparam int DATA_W = MAX_DW * 64;
    localparam int FREE_W = PTR_W - 4;
    localparam int CNT_W  = $clog2(MAX_DW + 1);

    typedef struct packed {
        rd_state_e          st;
        logic [PTR_W-1:0]   wp;
        logic [PTR_W-1:0]   end_wp;
        logic [PTR_W-1:0]   dwp;
        logic               ovr;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   ndw;
        logic [63:0]        hdr;
        logic [DATA_W-1:0]  data;
    } wr_regs_t;

    wr_regs_t r_q, r_d;

    logic [6:0]        len_bytes;
    logic [2:0]        n_desc;
    logic [3:0]        n_dword;
    logic [FREE_W-1:0] free_desc;
    logic [PTR_W-1:0]  step_base;
    logic [PTR_W-1:0]  dword_next;
    logic [PTR_W-1:0]  frame_bytes;
    logic [PTR_W-1:0]  frame_end;
    logic              fits;
    logic              accept;
    logic              refuse;
    logic [31:0]       hw0;
    logic [31:0]       hw1;

    rdesc_len_decode u_len (
        .is_fd     (frm_fdo[0]),
        .dlc       (frm_dlc),
        .len_bytes (len_bytes),
        .n_desc    (n_desc),
        .n_dword   (n_dword)
    );

    rdesc_free_space #(.PTR_W(PTR_W)) u_space (
        .wp        (r_q.wp),
        .rp        (sw_rd_ptr),
        .size      (cfg_size),
        .free_desc (free_desc)
    );

    assign step_base   = (r_q.st == ST_IDLE) ? r_q.wp : r_q.dwp;
    assign frame_bytes = {{(PTR_W-7){1'b0}}, n_desc, 4'b0000};

    rdesc_ring_add #(.PTR_W(PTR_W)) u_dword_step (
        .base   (step_base),
        .step   (PTR_W'(DWORD_BYTES)),
        .size   (cfg_size),
        .result (dword_next)
    );

    rdesc_ring_add #(.PTR_W(PTR_W)) u_frame_step (
        .base   (r_q.wp),
        .step   (frame_bytes),
        .size   (cfg_size),
        .result (frame_end)
    );

    // header assembly
    always_comb begin
        if (frm_ext) begin
            hw0 = {1'b1, frm_rtr, 1'b0, frm_id[28:0]};
        end else begin
            hw0 = {1'b0, frm_rtr, frm_id[11:0], 18'd0};
        end
        hw1 = {frm_dlc, frm_fdo, 22'd0, r_q.ovr, st_busoff, st_passive};
    end

    assign fits   = {{(FREE_W-3){1'b0}}, n_desc} <= free_desc;
    assign accept = (r_q.st == ST_IDLE) && frm_valid && cfg_enable && fits;
    assign refuse = (r_q.st == ST_IDLE) && frm_valid && cfg_enable && !fits;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st     = ST_HDR;
                    r_d.hdr    = {hw1, hw0};
                    r_d.ovr    = 1'b0;
                    r_d.data   = frm_data;
                    r_d.ndw    = CNT_W'(n_dword);
                    r_d.cnt    = '0;
                    r_d.dwp    = dword_next;
                    r_d.end_wp = frame_end;
                end else if (refuse) begin
                    r_d.ovr = 1'b1;
                end
            end
            ST_HDR: begin
                r_d.st = (r_q.ndw == '0) ? ST_COMMIT : ST_PAY;
            end
            ST_PAY: begin
                r_d.cnt = r_q.cnt + 1'b1;
                r_d.dwp = dword_next;
                if (r_q.cnt == r_q.ndw - 1'b1) begin
                    r_d.st = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                r_d.wp = r_q.end_wp;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = r_q.wp[PTR_W-1:3];
        mem_wdata = r_q.hdr;
        if (r_q.st == ST_HDR) begin
            mem_we = 1'b1;
        end else if (r_q.st == ST_PAY) begin
            mem_we    = 1'b1;
            mem_addr  = r_q.dwp[PTR_W-1:3];
            mem_wdata = r_q.data[r_q.cnt*64 +: 64];
        end
    end

    assign wr_ptr    = r_q.wp;
    assign frm_ready = (r_q.st == ST_IDLE);

    // R8
    commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_COMMIT) |=> $stable(wr_ptr));

    // R11
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !frm_ready);

    // R5
    addr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({mem_addr, 3'b000} < cfg_size));

    // R6
    no_catch_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_COMMIT) |-> (r_q.end_wp != sw_rd_ptr));

    // R9
    disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_ready && frm_valid && !cfg_enable) |=> (!mem_we && $stable(wr_ptr)));

    // R7
    overrun_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> (r_q.ovr && frm_ready && $stable(wr_ptr)));

endmodule

// File: tb/rdesc_ring_writer_test.sv
module rdesc_ring_writer_test;

    localparam int PTR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_enable = 1'b0;
    logic [PTR_W-1:0]  cfg_size = '0;
    logic [PTR_W-1:0]  sw_rd_ptr = '0;
    logic [PTR_W-1:0]  wr_ptr;
    logic              frm_valid = 1'b0;
    logic              frm_ready;
    logic              frm_ext = 1'b0;
    logic              frm_rtr = 1'b0;
    logic [28:0]       frm_id = '0;
    logic [3:0]        frm_dlc = '0;
    logic [2:0]        frm_fdo = '0;
    logic [511:0]      frm_data = '0;
    logic              st_busoff = 1'b0;
    logic              st_passive = 1'b0;
    logic              mem_we;
    logic [PTR_W-4:0]  mem_addr;
    logic [63:0]       mem_wdata;

    logic [63:0] ram [0:511];
    int wcnt = 0;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rdesc_ring_writer #(.PTR_W(PTR_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_size(cfg_size),
        .sw_rd_ptr(sw_rd_ptr), .wr_ptr(wr_ptr), .frm_valid(frm_valid),
        .frm_ready(frm_ready), .frm_ext(frm_ext), .frm_rtr(frm_rtr),
        .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_fdo(frm_fdo),
        .frm_data(frm_data), .st_busoff(st_busoff), .st_passive(st_passive),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
            wcnt <= wcnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] mkdata(input logic [31:0] seed);
        logic [511:0] d;
        for (int k = 0; k < 8; k++) d[64*k +: 64] = {seed, 32'(k)};
        return d;
    endfunction

    // expected header from R1 and R2
    function automatic logic [63:0] hdr(input logic ext, input logic rtr, input logic [28:0] id,
                                        input logic [3:0] dlc, input logic [2:0] fdo,
                                        input logic ovr, input logic bo, input logic ep);
        logic [31:0] w0;
        logic [31:0] w1;
        w0 = ext ? ({3'b100, 29'd0} | {3'b0, id}) : {2'b00, id[11:0], 18'd0};
        if (rtr) w0[30] = 1'b1;
        w1 = {dlc, fdo, 22'd0, ovr, bo, ep};
        return {w1, w0};
    endfunction

    task automatic send(input logic ext, input logic rtr, input logic [28:0] id,
                        input logic [3:0] dlc, input logic [2:0] fdo,
                        input logic bo, input logic ep, input logic [511:0] d);
        @(negedge clk);
        wcnt = 0;
        frm_ext = ext; frm_rtr = rtr; frm_id = id; frm_dlc = dlc; frm_fdo = fdo;
        st_busoff = bo; st_passive = ep; frm_data = d; frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        for (int i = 0; i < 40 && !frm_ready; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R10 wr_ptr", 64'(wr_ptr), 64'd0);
        chk("R10 ready", 64'(frm_ready), 64'd1);
        chk("R10 we", 64'(mem_we), 64'd0);
    endtask

    task automatic t_std_short;
        send(0, 0, 29'h5A3, 4'd3, 3'b000, 0, 0, mkdata(32'hA1));
        chk("R1 std hdr", ram[0], hdr(0, 0, 29'h5A3, 3, 0, 0, 0, 0));
        chk("R3 payload", ram[1], mkdata(32'hA1) & 512'hFFFF_FFFF_FFFF_FFFF);
        chk("R11 writes", 64'(wcnt), 64'd2);
        chk("R4 wr_ptr", 64'(wr_ptr), 64'd16);
    endtask

    task automatic t_ext_rtr;
        send(1, 1, 29'h1ABCDEF0, 4'd0, 3'b000, 0, 0, mkdata(32'hB2));
        chk("R1 ext hdr", ram[2], hdr(1, 1, 29'h1ABCDEF0, 0, 0, 0, 0, 0));
        chk("R3 no payload", 64'(wcnt), 64'd1);
        chk("R4 wr_ptr", 64'(wr_ptr), 64'd32);
    endtask

    task automatic t_classic_clamp;
        send(0, 0, 29'h7FF, 4'd12, 3'b000, 1, 1, mkdata(32'hC3));
        chk("R2 status hdr", ram[4], hdr(0, 0, 29'h7FF, 12, 0, 0, 1, 1));
        chk("R3 clamp writes", 64'(wcnt), 64'd2);
        chk("R4 wr_ptr", 64'(wr_ptr), 64'd48);
    endtask

    task automatic t_fd12;
        send(0, 0, 29'h123, 4'd9, 3'b011, 0, 0, mkdata(32'hD4));
        chk("R2 fdo hdr", ram[6], hdr(0, 0, 29'h123, 9, 3'b011, 0, 0, 0));
        chk("R3 fd12 dw0", ram[7], {32'hD4, 32'd0});
        chk("R3 fd12 dw1", ram[8], {32'hD4, 32'd1});
        chk("R11 fd12 writes", 64'(wcnt), 64'd3);
        chk("R4 two desc", 64'(wr_ptr), 64'd80);
    endtask

    task automatic t_no_room;
        send(0, 0, 29'h1, 4'd15, 3'b001, 0, 0, mkdata(32'hE5));
        chk("R7 drop writes", 64'(wcnt), 64'd0);
        chk("R7 drop ptr", 64'(wr_ptr), 64'd80);
    endtask

    task automatic t_fd64_wrap;
        sw_rd_ptr = 12'd64;
        send(1, 0, 29'h0ABCD, 4'd15, 3'b001, 0, 0, mkdata(32'hF6));
        chk("R7 ovr in hdr", ram[10], hdr(1, 0, 29'h0ABCD, 15, 3'b001, 1, 0, 0));
        for (int k = 0; k < 8; k++)
            chk("R5 wrap payload", ram[(11 + k) % 16], {32'hF6, 32'(k)});
        chk("R11 fd64 writes", 64'(wcnt), 64'd9);
        chk("R4 ptr wrap", 64'(wr_ptr), 64'd32);
    endtask

    task automatic t_fill_gap;
        send(0, 0, 29'h22, 4'd8, 3'b000, 0, 0, mkdata(32'h17));
        chk("R7 ovr cleared", ram[4], hdr(0, 0, 29'h22, 8, 0, 0, 0, 0));
        chk("R6 last fit", 64'(wr_ptr), 64'd48);
        send(0, 0, 29'h23, 4'd0, 3'b000, 0, 0, mkdata(32'h18));
        chk("R6 gap kept writes", 64'(wcnt), 64'd0);
        chk("R6 gap kept ptr", 64'(wr_ptr), 64'd48);
    endtask

    task automatic t_disabled;
        sw_rd_ptr = 12'd48;
        cfg_enable = 1'b0;
        send(0, 0, 29'h33, 4'd2, 3'b000, 0, 0, mkdata(32'h19));
        chk("R9 no writes", 64'(wcnt), 64'd0);
        chk("R9 ptr held", 64'(wr_ptr), 64'd48);
        cfg_enable = 1'b1;
        send(0, 0, 29'h34, 4'd1, 3'b000, 0, 0, mkdata(32'h1A));
        chk("R9 ovr untouched", ram[6], hdr(0, 0, 29'h34, 1, 0, 1, 0, 0));
        chk("R4 after enable", 64'(wr_ptr), 64'd64);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cfg_size = 12'd128;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cfg_enable = 1'b1;
        t_std_short();
        t_ext_rtr();
        t_classic_clamp();
        t_fd12();
        t_no_room();
        t_fd64_wrap();
        t_fill_gap();
        t_disabled();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule